// File: doc/BRIEF.md
# Indexed Register Alias Table

This unit sits as one extra pipeline step between instruction expansion and register renaming. The top half of the register number space is treated as an indexed region. For each operand of a decoded instruction, the unit looks at the top bit of the register number. When that bit is set and the feature enable is high, the unit replaces the low bits with a physical address read from a 64-entry alias table. Operands whose top bit is clear, and every operand while the enable is low, pass through unchanged.

A ready bit is kept for each physical target in the region. When an instruction with a remapped destination issues, its target becomes pending. A later instruction that reads a pending target through a remapped source is held in the stage and raises `stall`. It is released in the same cycle that the writeback for that target arrives. A separate port loads new mappings into the table.

The stage is a two-state machine. In ST_EMPTY the stage holds no instruction. In ST_LOADED it presents one. The transitions are as follows:
- EMPTY to LOADED on a decode.
- LOADED to LOADED while stalled, or on a decode that is not stalled.
- LOADED to EMPTY when the stage is not stalled and no decode is present.

Top module: `irat_top`

## Requirements
- R1: After reset `ren_valid` and `stall` are 0, every table entry maps index i to physical target i, and every target is ready.
- R2: An operand whose bit 6 is 0, or any operand decoded while `enable` is 0, appears on its `ren_*` output unchanged.
- R3: An operand decoded with `enable` = 1 and bit 6 = 1 appears as {1'b1, table[bits 5:0]}.
- R4: An instruction decoded in one cycle is presented on the `ren_*` outputs with `ren_valid` = 1 in the next cycle, when the stage is not stalled.
- R5: Issue happens when `ren_valid` = 1 and `stall` = 0. Issuing an instruction whose destination was remapped marks that destination's physical target pending.
- R6: `stall` is 1 while a presented instruction has a remapped source whose target is pending. During a stall the outputs hold and decode inputs are ignored. A writeback to that target drops `stall` in the same cycle.
- R7: Both sources are checked, and the instruction stalls if either remapped target is pending.
- R8: A mapping load takes effect for decodes in the next cycle. A decode in the same cycle as the load uses the old mapping.
- R9: An instruction decoded with `enable` = 0 never stalls and never marks a target pending.
- R10: If an issue marks a target pending in the same cycle that a writeback to that target arrives, the target ends pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Feature enable from the status register |
| dec_valid | input | 1 | A decoded instruction is present |
| src_a | input | 7 | First source register number |
| src_b | input | 7 | Second source register number |
| dst | input | 7 | Destination register number |
| map_we | input | 1 | Load a mapping |
| map_idx | input | 6 | Table entry to load |
| map_tgt | input | 6 | New physical target |
| wb_valid | input | 1 | Writeback event |
| wb_tgt | input | 6 | Physical target written back |
| ren_valid | output | 1 | Instruction presented to rename |
| ren_a | output | 7 | Renamed first source |
| ren_b | output | 7 | Renamed second source |
| ren_dst | output | 7 | Renamed destination |
| stall | output | 1 | Hold the decoder and this stage |

## Verification
The following properties are checked on every cycle:
- A stall keeps the presented instruction valid and its operands stable.
- Operands outside the region pass through unchanged.
- Remapped operands land in the region.
- A decode made with the feature disabled never stalls.

Some behaviour only the bench scenarios can show, because it depends on table and ready history that no single-cycle property can hold:
- The exact alias value read after a mapping load, including the old value seen in the load cycle.
- Pending state created by an issue.
- Release by writeback in the same cycle.
- Pending state winning over a writeback that collides with it.

// File: rtl/irat_pkg.sv
package irat_pkg;
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;
endpackage

// File: rtl/irat_map_table.sv
module irat_map_table #(
    parameter int IDX_W = 6,
    parameter int NPORT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx [NPORT],
    output logic [IDX_W-1:0] rd_tgt [NPORT]
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= IDX_W'(i);
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_tgt;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_tgt[p] = mem_q[rd_idx[p]];
    end
endmodule

// File: rtl/irat_ready_vec.sv
module irat_ready_vec #(
    parameter int IDX_W = 6,
    parameter int NQ    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] q_idx [NQ],
    output logic             q_avail [NQ]
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else begin
            if (set_en) rdy_q[set_idx] <= 1'b1;
            if (clr_en) rdy_q[clr_idx] <= 1'b0;
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign q_avail[q] = rdy_q[q_idx[q]] | (set_en && (set_idx == q_idx[q]));
    end
endmodule

// File: rtl/irat_stage.sv
module irat_stage
    import irat_pkg::*;
#(
    parameter int REG_W = 7,
    localparam int IDX_W = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] dst,
    input  logic [IDX_W-1:0] tgt_a,
    input  logic [IDX_W-1:0] tgt_b,
    input  logic [IDX_W-1:0] tgt_d,
    input  logic             avail_a,
    input  logic             avail_b,
    output logic [IDX_W-1:0] held_a,
    output logic [IDX_W-1:0] held_b,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ren_valid,
    output logic [REG_W-1:0] ren_a,
    output logic [REG_W-1:0] ren_b,
    output logic [REG_W-1:0] ren_dst,
    output logic             stall
);
    stage_state_e     state_q, state_d;
    logic             rm_a_q, rm_b_q, rm_d_q;
    logic [IDX_W-1:0] td_q;
    logic             capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = dec_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: if (!stall) state_d = dec_valid ? ST_LOADED : ST_EMPTY;
        endcase
    end

    always_comb begin
        ren_valid = (state_q == ST_LOADED);
        stall     = ren_valid && ((rm_a_q && !avail_a) || (rm_b_q && !avail_b));
        clr_en    = ren_valid && !stall && rm_d_q;
        clr_idx   = td_q;
        capture   = dec_valid && !stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rm_a_q  <= 1'b0;
            rm_b_q  <= 1'b0;
            rm_d_q  <= 1'b0;
            held_a  <= '0;
            held_b  <= '0;
            td_q    <= '0;
            ren_a   <= '0;
            ren_b   <= '0;
            ren_dst <= '0;
        end else if (capture) begin
            rm_a_q  <= enable && src_a[REG_W-1];
            rm_b_q  <= enable && src_b[REG_W-1];
            rm_d_q  <= enable && dst[REG_W-1];
            held_a  <= tgt_a;
            held_b  <= tgt_b;
            td_q    <= tgt_d;
            ren_a   <= (enable && src_a[REG_W-1]) ? {1'b1, tgt_a} : src_a;
            ren_b   <= (enable && src_b[REG_W-1]) ? {1'b1, tgt_b} : src_b;
            ren_dst <= (enable && dst[REG_W-1])   ? {1'b1, tgt_d} : dst;
        end
    end
endmodule

// File: rtl/irat_top.sv
module irat_top #(
    parameter int REG_W = 7,
    localparam int IDX_W = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] dst,
    input  logic             map_we,
    input  logic [IDX_W-1:0] map_idx,
    input  logic [IDX_W-1:0] map_tgt,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_tgt,
    output logic             ren_valid,
    output logic [REG_W-1:0] ren_a,
    output logic [REG_W-1:0] ren_b,
    output logic [REG_W-1:0] ren_dst,
    output logic             stall
);
    logic [IDX_W-1:0] rd_idx [3];
    logic [IDX_W-1:0] rd_tgt [3];
    logic [IDX_W-1:0] q_idx  [2];
    logic             q_av   [2];
    logic [IDX_W-1:0] held_a, held_b, clr_idx;
    logic             clr_en;

    assign rd_idx[0] = src_a[IDX_W-1:0];
    assign rd_idx[1] = src_b[IDX_W-1:0];
    assign rd_idx[2] = dst[IDX_W-1:0];
    assign q_idx[0]  = held_a;
    assign q_idx[1]  = held_b;

    irat_map_table #(.IDX_W(IDX_W), .NPORT(3)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_idx(map_idx), .wr_tgt(map_tgt),
        .rd_idx(rd_idx), .rd_tgt(rd_tgt)
    );

    irat_ready_vec #(.IDX_W(IDX_W), .NQ(2)) u_ready (
        .clk(clk), .rst_n(rst_n),
        .set_en(wb_valid), .set_idx(wb_tgt),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .q_idx(q_idx), .q_avail(q_av)
    );

    irat_stage #(.REG_W(REG_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dec_valid(dec_valid),
        .src_a(src_a), .src_b(src_b), .dst(dst),
        .tgt_a(rd_tgt[0]), .tgt_b(rd_tgt[1]), .tgt_d(rd_tgt[2]),
        .avail_a(q_av[0]), .avail_b(q_av[1]),
        .held_a(held_a), .held_b(held_b),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .ren_valid(ren_valid), .ren_a(ren_a), .ren_b(ren_b), .ren_dst(ren_dst),
        .stall(stall)
    );
endmodule

// File: rtl/irat_chk.sv
module irat_chk #(
    parameter int REG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             dec_valid,
    input logic [REG_W-1:0] src_a,
    input logic             ren_valid,
    input logic [REG_W-1:0] ren_a,
    input logic [REG_W-1:0] ren_b,
    input logic             stall
);
    // R6
    stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ren_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ren_valid && $stable(ren_a) && $stable(ren_b)));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && !src_a[REG_W-1]) |=> (ren_valid && ren_a == $past(src_a)));

    // R3
    remap_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && enable && src_a[REG_W-1]) |=> ren_a[REG_W-1]);

    // R9
    disabled_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && !enable) |=> !stall);
endmodule

bind irat_top irat_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dec_valid(dec_valid),
    .src_a(src_a), .ren_valid(ren_valid), .ren_a(ren_a), .ren_b(ren_b),
    .stall(stall)
);

// File: tb/irat_top_tb.sv
`timescale 1ns/1ps
module irat_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, dec_valid = 1'b0, map_we = 1'b0, wb_valid = 1'b0;
    logic [6:0] src_a = '0, src_b = '0, dst = '0;
    logic [5:0] map_idx = '0, map_tgt = '0, wb_tgt = '0;
    logic       ren_valid, stall;
    logic [6:0] ren_a, ren_b, ren_dst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] mm [64];
    bit         rdy [64];
    bit         m_v, rma, rmb, rmd;
    logic [5:0] ta, tb, td;
    logic [6:0] ea, eb, ed;

    always #2.5 clk = ~clk;

    irat_top u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dec_valid(dec_valid),
        .src_a(src_a), .src_b(src_b), .dst(dst),
        .map_we(map_we), .map_idx(map_idx), .map_tgt(map_tgt),
        .wb_valid(wb_valid), .wb_tgt(wb_tgt),
        .ren_valid(ren_valid), .ren_a(ren_a), .ren_b(ren_b), .ren_dst(ren_dst),
        .stall(stall)
    );

    function automatic bit avail(input logic [5:0] t);
        return rdy[t] || (wb_valid && wb_tgt == t);
    endfunction

    function automatic logic [6:0] xlate(input logic [6:0] r);
        return (enable && r[6]) ? {1'b1, mm[r[5:0]]} : r;
    endfunction

    task automatic cyc(input string tag, input bit dv, input bit en,
                       input logic [6:0] sa, input logic [6:0] sb, input logic [6:0] sd,
                       input bit mwe, input logic [5:0] mi, input logic [5:0] mt,
                       input bit wv, input logic [5:0] wi);
        bit m_stall, iss;
        @(negedge clk);
        dec_valid = dv; enable = en; src_a = sa; src_b = sb; dst = sd;
        map_we = mwe; map_idx = mi; map_tgt = mt; wb_valid = wv; wb_tgt = wi;
        #1;
        m_stall = m_v && ((rma && !avail(ta)) || (rmb && !avail(tb)));
        checks++;
        if (ren_valid !== m_v || stall !== m_stall ||
            (m_v && (ren_a !== ea || ren_b !== eb || ren_dst !== ed))) begin
            errors++;
            $display("FAIL %s: actual v=%0b st=%0b a=%h b=%h d=%h expected v=%0b st=%0b a=%h b=%h d=%h",
                     tag, ren_valid, stall, ren_a, ren_b, ren_dst,
                     m_v, m_stall, ea, eb, ed);
        end
        iss = m_v && !m_stall;
        if (wv) rdy[wi] = 1'b1;
        if (iss && rmd) rdy[td] = 1'b0;
        if (!m_stall) begin
            m_v = dv;
            if (dv) begin
                rma = en && sa[6]; rmb = en && sb[6]; rmd = en && sd[6];
                ta = mm[sa[5:0]]; tb = mm[sb[5:0]]; td = mm[sd[5:0]];
                ea = xlate(sa); eb = xlate(sb); ed = xlate(sd);
            end
        end
        if (mwe) mm[mi] = mt;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < 64; i++) begin
            mm[i] = 6'(i);
            rdy[i] = 1'b1;
        end
        m_v = 0; rma = 0; rmb = 0; rmd = 0; ta = 0; tb = 0; td = 0;
        ea = 0; eb = 0; ed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cyc("R1 reset idle",      0,1, 7'h00,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R1 identity decode", 1,1, 7'h7F,7'h40,7'h00, 0,0,0, 0,0);
        cyc("R2 msb clear",       1,1, 7'h12,7'h33,7'h01, 0,0,0, 0,0);
        cyc("R8 load same cycle", 1,1, 7'h45,7'h00,7'h00, 1,6'd5,6'd40, 0,0);
        cyc("R8 load next cycle", 1,1, 7'h45,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R4 latency",         1,1, 7'h00,7'h00,7'h45, 0,0,0, 0,0);
        cyc("R5 dst issue",       1,1, 7'h45,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R5 pending stalls",  1,1, 7'h01,7'h02,7'h03, 0,0,0, 0,0);
        cyc("R6 stall holds",     1,1, 7'h01,7'h02,7'h03, 0,0,0, 0,0);
        cyc("R6 wb releases",     1,1, 7'h01,7'h02,7'h03, 0,0,0, 1,6'd40);
        cyc("R7 dst second",      1,1, 7'h00,7'h00,7'h46, 0,0,0, 0,0);
        cyc("R7 src b decode",    1,1, 7'h01,7'h46,7'h00, 0,0,0, 0,0);
        cyc("R7 b pending",       1,1, 7'h01,7'h02,7'h00, 0,0,0, 0,0);
        cyc("R7 b release",       1,1, 7'h01,7'h02,7'h00, 0,0,0, 1,6'd6);
        cyc("R9 disabled dst",    1,0, 7'h00,7'h00,7'h46, 0,0,0, 0,0);
        cyc("R9 disabled src",    1,0, 7'h46,7'h46,7'h00, 0,0,0, 0,0);
        cyc("R9 no stall",        0,1, 7'h00,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R9 enabled src",     1,1, 7'h46,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R10 dst decode",     1,1, 7'h00,7'h00,7'h47, 0,0,0, 0,0);
        cyc("R10 clash",          1,1, 7'h47,7'h00,7'h00, 0,0,0, 1,6'd7);
        cyc("R10 stays pending",  0,1, 7'h00,7'h00,7'h00, 0,0,0, 0,0);
        cyc("R10 release",        0,1, 7'h00,7'h00,7'h00, 0,0,0, 1,6'd7);
        cyc("R4 drain",           0,1, 7'h00,7'h00,7'h00, 0,0,0, 0,0);

        for (int n = 0; n < 4000; n++) begin
            logic [6:0] sa, sb, sd;
            logic [5:0] wi;
            sa = 7'($urandom); sb = 7'($urandom); sd = 7'($urandom);
            wi = ($urandom % 2) ? ta : (($urandom % 2) ? tb : 6'($urandom));
            cyc("R3 random", ($urandom % 4) != 0, ($urandom % 8) != 0, sa, sb, sd,
                ($urandom % 6) == 0, 6'($urandom), 6'($urandom),
                ($urandom % 3) == 0, wi);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule